// File: doc/BRIEF.md
# Multi-Style Host Bus Front End

This block is the slave side of an 8-bit parallel host bus. A microcontroller or a PC parallel port in EPP mode uses it to reach an internal register bank. One set of pins serves five host bus styles:

- dedicated address pins with separate read and write strobes;
- an address/data bus with separate strobes, where an address latch enable captures the address;
- dedicated address pins with one data strobe and a read-not-write line;
- an address/data bus with one data strobe, where an address strobe captures the address;
- an EPP-style handshake with a wait output.

After every reset the block works out the bus style by itself from the pin levels. It then turns each host access into a simple register port: an address, write data, a one-cycle write enable, a one-cycle read enable, and read data.

Every asynchronous input passes through a two-stage synchronizer before it is used. The register port has no back-pressure. The bank must accept `reg_we` in the cycle it is raised, and it must present `reg_rdata` combinationally for `reg_addr` in the cycle `reg_re` is high. Flow control toward the host exists only in EPP mode, through `wait_o`.

Top module: `hbus_front`

## Requirements
- R1: The block detects the bus style once per reset. Detection waits until the synchronizers hold real pin values (SYNC_STAGES+1 clocks after reset release). Until then no access is accepted, and `bus_oe`, `wait_o` and `reg_we` stay low.
- R2: If `epp_strap` is high at detection, the EPP style is selected. It stays selected until the next reset.
- R3: If `epp_strap` is low and `wr_dir` is low at detection, a common-strobe style is selected. In these styles `rd_ds_n` low is the data strobe and `wr_dir` high means read. Otherwise a separate-strobe style is selected, with `rd_ds_n` as the read strobe and `wr_dir` as the write strobe, both active low.
- R4: In a non-EPP style, a rising edge on `ale_as` (active high) before the first data access switches the block to the matching multiplexed style. Once any data access has happened, the style no longer changes.
- R5: Each completed write produces exactly one single-clock `reg_we` pulse after the strobe is released. The pulse carries the data that was on the bus during the strobe and the address of that access.
- R6: `bus_oe` is high only while chip select and a read access are both active. During a read, `bus_out` returns `reg_rdata` for the addressed register. `reg_re` is a single-clock pulse for each read.
- R7: In EPP mode `wait_o` is low while idle. It rises one clock after the synchronized data or address strobe is seen active, and falls one clock after the strobe is seen released. Outside EPP mode `wait_o` stays low.
- R8: In EPP mode an address-strobe cycle (`ale_as` low) with `wr_dir` low stores the low 6 bits of the bus as the register address. With `wr_dir` high, the same cycle returns that stored address on `bus_out`. Data-strobe cycles use the stored address.
- R9: While `cs_n` is high, strobes have no effect: no `reg_we` pulse is produced and `bus_oe` stays low.
- R10: A new reset clears the detected style, and the style is detected again.
- R11: Addresses are zero-extended to 6 bits. A style with dedicated address pins uses `addr_pins`. A multiplexed style uses `bus_in[5:0]`, captured while `ale_as` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; starts a new detection |
| epp_strap | input | 1 | Strap that selects the EPP style |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Read strobe, or data strobe in common/EPP styles |
| wr_dir | input | 1 | Write strobe, or direction (high = read) in common/EPP styles |
| ale_as | input | 1 | Address latch/strobe; active high, active low in EPP |
| addr_pins | input | 3 | Dedicated address pins |
| bus_in | input | 8 | Data or address/data bus, input side |
| bus_out | output | 8 | Data bus, output side |
| bus_oe | output | 1 | Output enable for `bus_out` |
| wait_o | output | 1 | EPP handshake wait |
| reg_addr | output | 6 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | Register write enable, one clock per write |
| reg_re | output | 1 | Register read enable, one clock per read |
| reg_rdata | input | 8 | Register read data |

## Verification
A wrong detected style is the most likely internal fault. It shows at the register port on the first access after detection: a write lands on the wrong address, produces no `reg_we` pulse, or produces an extra one. A wrong multiplexed flag shows as the bus value used in place of the pin address, or the reverse. A broken EPP address register is exposed within the same access by an address-strobe read. A wait or output-enable fault shows within one clock of the strobe edge, which the bench samples at the exact expected cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    ST_DETECT,
    ST_SEP_SEP,
    ST_MUX_SEP,
    ST_SEP_COM,
    ST_MUX_COM,
    ST_EPP
  } style_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RST;
      else if (i == 0) st[i] <= d;
      else st[i] <= st[(i == 0) ? 0 : i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbus_detect.sv
module hbus_detect
  import hbus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   s_strap,
  input  logic   s_dir,
  input  logic   s_ale,
  input  logic   data_act,
  output style_e style
);
  localparam int CW = $clog2(STAGES + 1);

  logic [CW-1:0] cnt;
  logic done, epp, com, mux, seen, ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; done <= 1'b0; epp <= 1'b0; com <= 1'b0;
      mux <= 1'b0; seen <= 1'b0; ale_q <= 1'b1;
    end else begin
      ale_q <= s_ale;
      if (!done) begin
        if (cnt == CW'(STAGES)) begin
          done <= 1'b1;
          epp  <= s_strap;
          com  <= !s_strap && !s_dir;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!epp) begin
        if (data_act) seen <= 1'b1;
        else if (!seen && s_ale && !ale_q) mux <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!done)     style = ST_DETECT;
    else if (epp)  style = ST_EPP;
    else if (com)  style = mux ? ST_MUX_COM : ST_SEP_COM;
    else           style = mux ? ST_MUX_SEP : ST_SEP_SEP;
  end
endmodule

// File: rtl/hbus_access.sv
module hbus_access
  import hbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int SEP_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  style_e            style,
  input  logic              s_cs_n,
  input  logic              s_ds_n,
  input  logic              s_dir,
  input  logic              s_as,
  input  logic [SEP_AW-1:0] s_addr,
  input  logic [DW-1:0]     s_bus,
  input  logic [DW-1:0]     reg_rdata,
  output logic [AW-1:0]     reg_addr,
  output logic [DW-1:0]     reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe,
  output logic              wait_o,
  output logic              data_act
);
  logic epp, com, mux, sel, d_lvl;
  logic rd_act, wr_act, a_act, a_rd, a_wr;
  logic rd_q, wr_q, aw_q;
  logic [AW-1:0] mux_addr, epp_addr, addr_q, cur_addr;
  logic [DW-1:0] wlatch, rd_hold;

  always_comb begin
    epp   = (style == ST_EPP);
    com   = (style == ST_SEP_COM) || (style == ST_MUX_COM);
    mux   = (style == ST_MUX_SEP) || (style == ST_MUX_COM);
    sel   = (style != ST_DETECT) && !s_cs_n;
    d_lvl = sel && !s_ds_n;
    if (epp || com) begin
      rd_act = d_lvl && s_dir;
      wr_act = d_lvl && !s_dir;
    end else begin
      rd_act = d_lvl;
      wr_act = sel && !s_dir;
    end
    a_act = sel && epp && !s_as;
    a_rd  = a_act && s_dir;
    a_wr  = a_act && !s_dir;
    if (epp)      cur_addr = epp_addr;
    else if (mux) cur_addr = mux_addr;
    else          cur_addr = AW'(s_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0; wr_q <= 1'b0; aw_q <= 1'b0;
      mux_addr <= '0; epp_addr <= '0; addr_q <= '0;
      wlatch <= '0; rd_hold <= '0;
      reg_we <= 1'b0; reg_re <= 1'b0; wait_o <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      aw_q <= a_wr;
      if (!epp && s_as) mux_addr <= s_bus[AW-1:0];
      if (wr_act || a_wr) wlatch <= s_bus;
      if (wr_act || rd_act) addr_q <= cur_addr;
      reg_we <= wr_q && !wr_act;
      reg_re <= rd_act && !rd_q;
      if (reg_re) rd_hold <= reg_rdata;
      if (aw_q && !a_wr) epp_addr <= wlatch[AW-1:0];
      wait_o <= epp && (d_lvl || a_act);
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wlatch;
  assign bus_oe    = rd_act || a_rd;
  assign bus_out   = a_rd ? DW'(epp_addr) : rd_hold;
  assign data_act  = rd_act || wr_act;
endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int SEP_AW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              epp_strap,
  input  logic              cs_n,
  input  logic              rd_ds_n,
  input  logic              wr_dir,
  input  logic              ale_as,
  input  logic [SEP_AW-1:0] addr_pins,
  input  logic [DW-1:0]     bus_in,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe,
  output logic              wait_o,
  output logic [AW-1:0]     reg_addr,
  output logic [DW-1:0]     reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DW-1:0]     reg_rdata
);
  localparam int SW = 5 + SEP_AW + DW;

  logic [SW-1:0]     s_vec;
  logic              s_strap, s_cs_n, s_ds_n, s_dir, s_as;
  logic [SEP_AW-1:0] s_addr;
  logic [DW-1:0]     s_bus;
  logic              data_act;
  style_e            style;

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({epp_strap, cs_n, rd_ds_n, wr_dir, ale_as, addr_pins, bus_in}),
    .q(s_vec)
  );

  assign {s_strap, s_cs_n, s_ds_n, s_dir, s_as, s_addr, s_bus} = s_vec;

  hbus_detect #(.STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst_n(rst_n), .s_strap(s_strap), .s_dir(s_dir),
    .s_ale(s_as), .data_act(data_act), .style(style)
  );

  hbus_access #(.DW(DW), .AW(AW), .SEP_AW(SEP_AW)) u_access (
    .clk(clk), .rst_n(rst_n), .style(style), .s_cs_n(s_cs_n),
    .s_ds_n(s_ds_n), .s_dir(s_dir), .s_as(s_as), .s_addr(s_addr),
    .s_bus(s_bus), .reg_rdata(reg_rdata), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .bus_out(bus_out), .bus_oe(bus_oe), .wait_o(wait_o),
    .data_act(data_act)
  );
endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk
  import hbus_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   reg_we,
  input logic   reg_re,
  input logic   bus_oe,
  input logic   wait_o,
  input logic   s_cs_n,
  input style_e style
);
  p_style_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (style != ST_DETECT) |=> (style != ST_DETECT));
  p_quiet_detect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (style == ST_DETECT) |-> (!reg_we && !bus_oe && !wait_o));
  p_epp_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (style == ST_EPP) |=> (style == ST_EPP));
  p_com_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (style == ST_SEP_COM) |=> (style == ST_SEP_COM || style == ST_MUX_COM));
  p_mux_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (style == ST_MUX_SEP) |=> (style == ST_MUX_SEP));
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_re_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_oe_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !s_cs_n);
  p_wait_epp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (style == ST_EPP));
endmodule

bind hbus_front hbus_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
  .bus_oe(bus_oe), .wait_o(wait_o), .s_cs_n(s_cs_n), .style(style)
);

// File: tb/test_hbus_front.sv
module test_hbus_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epp_strap = 1'b0, cs_n = 1'b1, rd_ds_n = 1'b1, wr_dir = 1'b1, ale_as = 1'b0;
  logic [2:0] addr_pins = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out, reg_wdata, reg_rdata;
  logic bus_oe, wait_o, reg_we, reg_re;
  logic [5:0] reg_addr;

  int checks = 0;
  int errs = 0;
  logic [13:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] model(input logic [5:0] a);
    return {a, 2'b11} ^ 8'hC3;
  endfunction

  assign reg_rdata = model(reg_addr);

  hbus_front i_hbus_front (
    .clk(clk), .rst_n(rst_n), .epp_strap(epp_strap), .cs_n(cs_n),
    .rd_ds_n(rd_ds_n), .wr_dir(wr_dir), .ale_as(ale_as),
    .addr_pins(addr_pins), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .wait_o(wait_o), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Scoreboard monitor: every reg_we pulse must match one queued write (R5)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R5 unexpected write actual=%0h/%0h expected=none", reg_addr, reg_wdata);
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({reg_addr, reg_wdata} !== e) begin
          errs++;
          $display("FAIL %s write actual=%0h expected=%0h", t, {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  task automatic push(input logic [5:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  task automatic do_reset(input logic strap, input logic dir);
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; rd_ds_n = 1'b1; wr_dir = dir;
    ale_as = strap; epp_strap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // com: 0 separate strobes, 1 common strobe / EPP data strobe
  task automatic wr_cyc(input bit com, input logic [2:0] a, input logic [7:0] d);
    addr_pins = a; bus_in = d; cs_n = 1'b0; wr_dir = 1'b0;
    if (com) rd_ds_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_ds_n = 1'b1; wr_dir = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_cyc(input logic [2:0] a, input logic [5:0] ea, input string t);
    addr_pins = a; wr_dir = 1'b1; cs_n = 1'b0; rd_ds_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(t, bus_oe, 1'b1);
    chk(t, bus_out, model(ea));
    rd_ds_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(t, bus_oe, 1'b0);
  endtask

  task automatic ale_pulse(input logic [7:0] v);
    bus_in = v; ale_as = 1'b1;
    repeat (4) @(negedge clk);
    ale_as = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // separate address, separate strobes
    do_reset(1'b0, 1'b1);
    chk("R1 reset oe", bus_oe, 1'b0);
    chk("R1 reset wait", wait_o, 1'b0);
    chk("R1 reset we", reg_we, 1'b0);
    push(6'd5, 8'hA5, "R5 sep write"); wr_cyc(1'b0, 3'd5, 8'hA5);
    push(6'd2, 8'h3C, "R11 sep write"); wr_cyc(1'b0, 3'd2, 8'h3C);
    rd_cyc(3'd5, 6'd5, "R6 sep read");
    chk("R7 no wait outside EPP", wait_o, 1'b0);
    // R9: strobes with chip select high do nothing
    addr_pins = 3'd1; bus_in = 8'hEE; wr_dir = 1'b0;
    repeat (4) @(negedge clk);
    wr_dir = 1'b1; rd_ds_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 oe with cs high", bus_oe, 1'b0);
    rd_ds_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4: ALE after a data access does not switch style
    ale_pulse(8'h3F);
    push(6'd1, 8'h11, "R4 ale late ignored"); wr_cyc(1'b0, 3'd1, 8'h11);

    // multiplexed, separate strobes
    do_reset(1'b0, 1'b1);
    ale_pulse(8'h2A);
    push(6'h2A, 8'h77, "R4 mux write"); wr_cyc(1'b0, 3'd3, 8'h77);
    ale_pulse(8'h15);
    rd_cyc(3'd3, 6'h15, "R11 mux read");

    // separate address, common strobe
    do_reset(1'b0, 1'b0);
    push(6'd6, 8'h99, "R3 com write"); wr_cyc(1'b1, 3'd6, 8'h99);
    rd_cyc(3'd6, 6'd6, "R3 com read");

    // multiplexed, common strobe
    do_reset(1'b0, 1'b0);
    ale_pulse(8'h33);
    push(6'h33, 8'hE1, "R3 mux com write"); wr_cyc(1'b1, 3'd0, 8'hE1);

    // EPP
    do_reset(1'b1, 1'b1);
    chk("R2 epp idle wait", wait_o, 1'b0);
    bus_in = 8'h5B; cs_n = 1'b0; wr_dir = 1'b0; ale_as = 1'b0;
    repeat (4) @(negedge clk);
    ale_as = 1'b1; wr_dir = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 no write from address cycle", reg_we, 1'b0);
    cs_n = 1'b0; ale_as = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 address read oe", bus_oe, 1'b1);
    chk("R8 address read", bus_out, 8'h1B);
    ale_as = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    push(6'h1B, 8'h4D, "R8 epp data write"); wr_cyc(1'b1, 3'd7, 8'h4D);
    // R7: wait timing during an EPP data read
    wr_dir = 1'b1; cs_n = 1'b0; rd_ds_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 wait not yet", wait_o, 1'b0);
    @(negedge clk);
    chk("R7 wait high", wait_o, 1'b1);
    repeat (2) @(negedge clk);
    chk("R2 epp read", bus_out, model(6'h1B));
    rd_ds_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 wait held", wait_o, 1'b1);
    @(negedge clk);
    chk("R7 wait released", wait_o, 1'b0);
    repeat (3) @(negedge clk);

    // R10: reset again, separate style returns
    do_reset(1'b0, 1'b1);
    push(6'd4, 8'h21, "R10 redetect write"); wr_cyc(1'b0, 3'd4, 8'h21);
    chk("R10 no wait", wait_o, 1'b0);

    repeat (5) @(negedge clk);
    chk("R5 all writes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule